// File: doc/BRIEF.md
# Framed Serial Row-Scan Sequencer

This block sequences a row-multiplexed stimulator array that is fed by one serial stream. A serial-to-parallel register outside the block shifts in one bit per clock. The sequencer watches the low 16 bits of that register and knows only the bit count. After reset it hunts for a start pattern. It then lets one 40-bit configuration packet pass and strobes the pulse timer once to capture it. After that it receives frames. Each frame is five 40-bit row packets followed by a 40-bit sync packet.

The sequencer does not address pixels. At every packet boundary it latches the shifted row into the parallel holding register. On the same boundary it steps a six-stage one-hot row selector, so the whole row is driven at once and the rows take turns. In each row packet the least significant byte belongs to the last column and the most significant byte to the first column. The external register handles that byte order. At the end of each frame the sync pattern must be present. If it is, the next frame starts two cycles later with no start or configuration packet. If it is not, the sequencer falls back to hunting.

Top module: `stim_frame_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the hunting state, `clear_o` is 1. `cfg_o`, `timer_arm_o`, `scan_en_o`, `row_latch_o` and `row_step_o` are 0, and `row_sel_o` is 6'b000001. Reset is asynchronous and takes effect from any state.
- R2: While hunting, every monitored word other than START_WORD (16'hEEEE) is ignored. This includes the sync value 16'hAAAA. No strobe occurs and `scan_en_o` stays 0.
- R3: Call E0 the clock edge that samples 16'hEEEE while hunting. `cfg_o` is then high for exactly one cycle, the 41st cycle after E0. `clear_o` is 0 from that cycle onward.
- R4: The cycle after the `cfg_o` strobe is the first cycle of row receive. From there `scan_en_o` and `timer_arm_o` are 1, and packets of PKT_BITS (40) cycles follow back to back.
- R5: In the first cycle after each 40-cycle packet, `row_latch_o` and `row_step_o` are both high for exactly one cycle. `timer_arm_o` is 0 in that cycle.
- R6: A frame is six packets: rows 1 to 5, then the sync packet. The monitored word is compared with SYNC_WORD (16'hAAAA) in the strobe cycle of the sixth packet. On a match, one more cycle follows with `scan_en_o` high and `timer_arm_o` low, and then the next frame's row 1 begins. The next frame carries no start or configuration packet.
- R7: If the sync comparison fails, the sequencer returns to hunting (R1 outputs) in the next cycle. It restarts only on a new start word.
- R8: `row_sel_o` is one-hot over six stages. Bit 0 is the idle stage and bit k selects row k. While `scan_en_o` is 0 it holds bit 0. At the end of each `row_step_o` cycle it advances one stage, and it wraps from bit 5 to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock, one serial bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_word_i | input | 16 | Low 16 bits of the external shift register |
| clear_o | output | 1 | Holds the holding register cleared until configuration is taken |
| cfg_o | output | 1 | One-cycle strobe: pulse timer captures the low 18 configuration bits |
| timer_arm_o | output | 1 | High lets the pulse timer run; a low cycle reloads it |
| scan_en_o | output | 1 | Releases the row selector from its idle stage |
| row_latch_o | output | 1 | One-cycle strobe moving a full row into the holding register |
| row_step_o | output | 1 | One-cycle strobe advancing the row selector |
| row_sel_o | output | 6 | One-hot row selector, bit 0 is the idle stage |

## Verification
The bench hunts through words that differ from the start pattern by one bit, and also through the sync pattern, to show that only the exact start word opens a stream. Two frames with a correct sync word show that boundary strobes repeat on a 242-cycle frame period and that the selector wraps. A third frame ends with a sync word off by one bit, which must drop the block back to hunting; a following start word must rebuild the stream from a fresh configuration. A reset in the middle of a row shows that the block leaves any state at once.

// File: rtl/stim_seq_pkg.sv
package stim_seq_pkg;
  typedef enum logic [2:0] {
    ST_HUNT     = 3'd0,
    ST_CFG_RX   = 3'd1,
    ST_CFG_GO   = 3'd2,
    ST_ROW_RX   = 3'd3,
    ST_SYNC_CHK = 3'd4,
    ST_SYNC_OK  = 3'd5
  } seq_state_e;
endpackage

// File: rtl/bit_tally.sv
// Wrapping counter: counts enabled cycles and flags the last value before wrap.
module bit_tally #(
  parameter int LIMIT = 40,
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  output logic last_o
);
  logic [CW-1:0] cnt_q, cnt_d;

  assign last_o = (cnt_q == CW'(LIMIT - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (en_i)   cnt_d = last_o ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/row_ring.sv
// One-hot ring of STAGES flops; stage 0 is the preset idle stage.
module row_ring #(
  parameter int STAGES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_i,
  input  logic              step_i,
  output logic [STAGES-1:0] sel_o
);
  logic [STAGES-1:0] sel_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    localparam logic PRESET = (i == 0);
    localparam int   PREV   = (i == 0) ? STAGES - 1 : i - 1;
    logic d;
    always_comb begin
      d = sel_q[i];
      if (hold_i)      d = PRESET;
      else if (step_i) d = sel_q[PREV];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q[i] <= PRESET;
      else        sel_q[i] <= d;
    end
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import stim_seq_pkg::*;
#(
  parameter int          MON_W      = 16,
  parameter logic [15:0] START_WORD = 16'hEEEE,
  parameter logic [15:0] SYNC_WORD  = 16'hAAAA
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MON_W-1:0] mon_word_i,
  input  logic             bit_last_i,
  input  logic             pkt_last_i,
  output logic             bit_en_o,
  output logic             bit_clr_o,
  output logic             pkt_en_o,
  output logic             pkt_clr_o,
  output logic             clear_o,
  output logic             cfg_o,
  output logic             arm_o,
  output logic             scan_o,
  output logic             strobe_o
);
  seq_state_e state_q, state_d;
  logic       edge_q, edge_d;
  logic       start_hit, sync_hit;

  assign start_hit = (mon_word_i[15:0] == START_WORD);
  assign sync_hit  = (mon_word_i[15:0] == SYNC_WORD);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_HUNT:     if (start_hit) state_d = ST_CFG_RX;
      ST_CFG_RX:   if (bit_last_i) state_d = ST_CFG_GO;
      ST_CFG_GO:   state_d = ST_ROW_RX;
      ST_ROW_RX:   if (bit_last_i && pkt_last_i) state_d = ST_SYNC_CHK;
      ST_SYNC_CHK: state_d = sync_hit ? ST_SYNC_OK : ST_HUNT;
      ST_SYNC_OK:  state_d = ST_ROW_RX;
      default:     state_d = ST_HUNT;
    endcase
  end

  assign edge_d = (state_q == ST_ROW_RX) && bit_last_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      edge_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      edge_q  <= edge_d;
    end
  end

  assign bit_en_o  = (state_q == ST_CFG_RX) || (state_q == ST_ROW_RX);
  assign bit_clr_o = !bit_en_o;
  assign pkt_en_o  = (state_q == ST_ROW_RX) && bit_last_i;
  assign pkt_clr_o = !((state_q == ST_ROW_RX) || (state_q == ST_SYNC_CHK));

  assign clear_o  = (state_q == ST_HUNT) || (state_q == ST_CFG_RX);
  assign cfg_o    = (state_q == ST_CFG_GO);
  assign scan_o   = (state_q == ST_ROW_RX) || (state_q == ST_SYNC_CHK) ||
                    (state_q == ST_SYNC_OK);
  assign arm_o    = (state_q == ST_ROW_RX) && !edge_q;
  assign strobe_o = edge_q;
endmodule

// File: rtl/stim_frame_ctrl.sv
module stim_frame_ctrl #(
  parameter int          PKT_BITS   = 40,
  parameter int          ROWS       = 5,
  parameter int          MON_W      = 16,
  parameter logic [15:0] START_WORD = 16'hEEEE,
  parameter logic [15:0] SYNC_WORD  = 16'hAAAA,
  localparam int         PKTS       = ROWS + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MON_W-1:0] mon_word_i,
  output logic             clear_o,
  output logic             cfg_o,
  output logic             timer_arm_o,
  output logic             scan_en_o,
  output logic             row_latch_o,
  output logic             row_step_o,
  output logic [ROWS:0]    row_sel_o
);
  logic bit_en, bit_clr, bit_last;
  logic pkt_en, pkt_clr, pkt_last;
  logic strobe;

  bit_tally #(.LIMIT(PKT_BITS)) u_bits (
    .clk(clk), .rst_n(rst_n), .clr_i(bit_clr), .en_i(bit_en), .last_o(bit_last)
  );

  bit_tally #(.LIMIT(PKTS)) u_pkts (
    .clk(clk), .rst_n(rst_n), .clr_i(pkt_clr), .en_i(pkt_en), .last_o(pkt_last)
  );

  seq_fsm #(
    .MON_W(MON_W), .START_WORD(START_WORD), .SYNC_WORD(SYNC_WORD)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .mon_word_i(mon_word_i),
    .bit_last_i(bit_last), .pkt_last_i(pkt_last),
    .bit_en_o(bit_en), .bit_clr_o(bit_clr),
    .pkt_en_o(pkt_en), .pkt_clr_o(pkt_clr),
    .clear_o(clear_o), .cfg_o(cfg_o), .arm_o(timer_arm_o),
    .scan_o(scan_en_o), .strobe_o(strobe)
  );

  row_ring #(.STAGES(PKTS)) u_ring (
    .clk(clk), .rst_n(rst_n), .hold_i(!scan_en_o), .step_i(strobe),
    .sel_o(row_sel_o)
  );

  assign row_latch_o = strobe;
  assign row_step_o  = strobe;
endmodule

// File: rtl/stim_frame_ctrl_chk.sv
module stim_frame_ctrl_chk #(
  parameter int ROWS = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clear_o,
  input logic          cfg_o,
  input logic          timer_arm_o,
  input logic          scan_en_o,
  input logic          row_latch_o,
  input logic          row_step_o,
  input logic [ROWS:0] row_sel_o
);
  AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    clear_o |-> (!scan_en_o && !row_latch_o && !cfg_o && !timer_arm_o)); // R1

  AST_CFG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o |=> (!cfg_o && timer_arm_o && scan_en_o)); // R3

  AST_STROBE_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    row_latch_o |-> (!timer_arm_o && scan_en_o)); // R5

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    row_step_o |=> !row_step_o); // R5

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(row_sel_o) == 1); // R8

  AST_IDLE_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en_o |-> row_sel_o[0]); // R8

  AST_SEL_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    row_step_o |=> (row_sel_o == {$past(row_sel_o[ROWS-1:0]), $past(row_sel_o[ROWS])})); // R8
endmodule

bind stim_frame_ctrl stim_frame_ctrl_chk #(.ROWS(ROWS)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear_o(clear_o), .cfg_o(cfg_o),
  .timer_arm_o(timer_arm_o), .scan_en_o(scan_en_o),
  .row_latch_o(row_latch_o), .row_step_o(row_step_o), .row_sel_o(row_sel_o)
);

// File: tb/stim_frame_ctrl_tb.sv
module stim_frame_ctrl_tb;
  logic        clk;
  logic        rst_n;
  logic [15:0] mon;
  logic        clear_o, cfg_o, arm_o, scan_o, latch_o, step_o;
  logic [5:0]  sel;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  typedef struct {
    int         at;
    bit         is_cfg;
    logic [5:0] sel;
  } exp_t;
  exp_t q[$];

  stim_frame_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .mon_word_i(mon),
    .clear_o(clear_o), .cfg_o(cfg_o), .timer_arm_o(arm_o),
    .scan_en_o(scan_o), .row_latch_o(latch_o), .row_step_o(step_o),
    .row_sel_o(sel)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic wait_cyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic chk_idle(input string req);
    chk(clear_o && !cfg_o && !arm_o && !scan_o && !latch_o && !step_o,
        req, "idle controls", {clear_o, cfg_o, arm_o, scan_o, latch_o, step_o}, 6'b100000);
    chk(sel == 6'b000001, req, "idle selector", sel, 6'b000001);
  endtask

  // Monitor: pops an expected strobe for every strobe the design shows.
  bit         pend = 0;
  logic [5:0] next_sel;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend) begin
        chk(sel == next_sel, "R8", "selector after step", sel, next_sel);
        pend = 0;
      end
      if (cfg_o || latch_o || step_o) begin
        if (q.size() == 0) begin
          chk(0, cfg_o ? "R3" : "R5", "unexpected strobe", cyc, -1);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (e.is_cfg) begin
            chk(cfg_o && !latch_o && cyc == e.at, "R3", "cfg strobe cycle", cyc, e.at);
            chk(!clear_o, "R3", "clear released", clear_o, 0);
          end else begin
            chk(latch_o && step_o && !cfg_o && cyc == e.at, "R5", "row strobe cycle", cyc, e.at);
            chk(!arm_o, "R5", "arm low at strobe", arm_o, 0);
            chk(sel == e.sel, "R8", "selector at strobe", sel, e.sel);
            next_sel = {sel[4:0], sel[5]};
            pend = 1;
          end
        end
      end
    end
  end

  // Start word plus configuration packet; returns first row-receive cycle.
  task automatic start_stream(output int f);
    int base;
    base = cyc;
    q.push_back('{base + 41, 1'b1, 6'd0});
    mon = 16'hEEEE;
    @(negedge clk);
    mon = 16'h0000;
    wait_cyc(base + 40);
    chk(clear_o && !scan_o, "R3", "clear held before cfg", clear_o, 1);
    f = base + 42;
    wait_cyc(f);
    chk(scan_o && arm_o && !clear_o, "R4", "row receive entered", {scan_o, arm_o}, 2'b11);
  endtask

  // One frame starting at row-receive cycle f.
  task automatic run_frame(input int f, input logic [15:0] sw, input bit good);
    for (int k = 1; k <= 6; k++) q.push_back('{f + 40 * k, 1'b0, 6'(1 << (k - 1))});
    wait_cyc(f + 20);
    chk(arm_o && scan_o, "R4", "arm mid packet", arm_o, 1);
    wait_cyc(f + 240);
    mon = sw;
    @(negedge clk);
    mon = 16'h0000;
    if (good) begin
      chk(scan_o && !arm_o && !latch_o, "R6", "sync accepted gap", {scan_o, arm_o}, 2'b10);
      @(negedge clk);
      chk(scan_o && arm_o && !cfg_o, "R6", "next frame row 1", {scan_o, arm_o}, 2'b11);
    end else begin
      chk_idle("R7");
    end
  endtask

  initial begin
    int f;
    mon   = 16'h0000;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk_idle("R1");
    rst_n = 1'b1;
    @(negedge clk);
    // R2: near-miss words and the sync word do not open a stream
    mon = 16'hEEEF; @(negedge clk);
    mon = 16'hAAAA; @(negedge clk);
    mon = 16'h6EEE; @(negedge clk);
    mon = 16'h0000;
    repeat (50) @(negedge clk);
    chk(!scan_o && clear_o && q.size() == 0, "R2", "still hunting", scan_o, 0);
    start_stream(f);
    run_frame(f, 16'hAAAA, 1'b1);
    run_frame(f + 242, 16'hAAAA, 1'b1);
    run_frame(f + 484, 16'hAAAB, 1'b0);
    repeat (60) @(negedge clk);
    chk(!scan_o && q.size() == 0, "R7", "stays hunting", scan_o, 0);
    // restart after the failed sync
    start_stream(f);
    run_frame(f, 16'hAAAA, 1'b1);
    // reset in the middle of a row
    f = f + 242;
    q.push_back('{f + 40, 1'b0, 6'b000001});
    q.push_back('{f + 80, 1'b0, 6'b000010});
    wait_cyc(f + 100);
    rst_n = 1'b0;
    #1;
    chk_idle("R1");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk_idle("R1");
    chk(q.size() == 0, "R5", "all expected strobes seen", q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired at cycle %0d: actual running expected done", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule